// File: doc/BRIEF.md
# Interrupt Request and CPU Power-Down Controller

This block collects one-cycle interrupt request pulses from up to sixteen peripheral sources into a flag register. It gates those flags with a per-source enable register and a one-bit global gate, and drives a single interrupt line toward the processor. Software reaches the registers through a small word-wide port: a two-bit register select, a write strobe with write data, and a combinational read-data bus. Pending flags are acknowledged by writing ones to them.

The same port carries a write-only power-down register. Writing it parks the processor in one of two paused states, chosen by one data bit. The light state (halt) ends by itself on the first cycle in which an enabled source has a pending flag, whatever the global gate holds. The deep state (stop) also raises an indication that other subsystems use to pause themselves, and it ends only on a dedicated wake input or on reset.

Register select encoding: 0 = source enable, 1 = pending flags, 2 = global gate, 3 = power-down.

Top module: `irq_halt_unit`

## Requirements
- R1: After reset the enable, flag and global gate registers read 0, the power state is running, and `cpuIrq`, `cpuPaused` and `stopOut` are low.
- R2: Register select 0 is a plain 16-bit enable register; a write stores the value and a read returns it unchanged.
- R3: Register select 2 is the global gate: writing any nonzero value makes it 1, writing zero makes it 0, and a read returns 16'h0000 or 16'h0001.
- R4: Register select 1 returns the pending flags; a write clears exactly the flags whose write-data bit is 1 and leaves the others unchanged.
- R5: A high `srcReq[i]` in a cycle sets flag i at that clock edge; when a request and an acknowledge hit the same bit in the same cycle, the flag ends up set.
- R6: `cpuIrq` is high exactly when the global gate is 1 and at least one bit is set in both the enable and the flag registers.
- R7: A write to register select 3 while running enters stop if write-data bit 7 is 1 and halt if bit 7 is 0; a read of select 3 returns 0; writes to select 3 while halted or stopped are ignored.
- R8: In halt `cpuPaused` is high; the state returns to running at the first clock edge at which enable AND flags is nonzero, independent of the global gate.
- R9: In stop both `cpuPaused` and `stopOut` are high; pending enabled flags do not end it, and a high `wakeIn` returns it to running at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| srcReq | input | 16 | Per-source request pulses |
| wakeIn | input | 1 | External wake from the stop state |
| cpuIrq | output | 1 | Interrupt line to the processor |
| cpuPaused | output | 1 | Processor is halted or stopped |
| stopOut | output | 1 | Stop indication for other subsystems |

## Verification
The flag logic is driven with requests alone, acknowledges alone, acknowledges with zero data, and a request and acknowledge on the same bit in one cycle. Together these separate set-wins priority from clear-wins and from a plain overwrite. The interrupt line is tried with the gate off, with a pending flag whose enable is clear, and with both present, which tells the gate from the enable mask. Halt wake is tried with an unenabled request, an enabled request, and an enabled flag that is already pending when halt is written; this distinguishes the enable mask, the one-edge wake latency and the immediate exit. Stop is tried with an enabled request and then the wake input, which shows that only the dedicated wake ends it.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_FLAGS  = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_GATE   = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_POWER  = 2'd3;
  localparam int STOP_BIT = 7;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_HALT = 2'd1,
    PWR_STOP = 2'd2
  } pwr_state_t;

  typedef struct packed {
    logic enableWr;
    logic flagAck;
    logic gateWr;
  } reg_strobe_t;

endpackage

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_halt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              stopSel,
  input  logic              pendingAny,
  input  logic              wakeIn,
  output reg_strobe_t       strobe,
  output pwr_state_t        pwrState
);

  pwr_state_t pwrNext;
  logic       powerWr;

  always_comb begin
    strobe          = '0;
    strobe.enableWr = regWrEn && (regAddr == SEL_ENABLE);
    strobe.flagAck  = regWrEn && (regAddr == SEL_FLAGS);
    strobe.gateWr   = regWrEn && (regAddr == SEL_GATE);
    powerWr         = regWrEn && (regAddr == SEL_POWER);
  end

  always_comb begin
    pwrNext = pwrState;
    unique case (pwrState)
      PWR_RUN: begin
        if (powerWr) pwrNext = stopSel ? PWR_STOP : PWR_HALT;
      end
      PWR_HALT: begin
        if (pendingAny) pwrNext = PWR_RUN;
      end
      PWR_STOP: begin
        if (wakeIn) pwrNext = PWR_RUN;
      end
      default: pwrNext = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwrState <= PWR_RUN;
    else       pwrState <= pwrNext;
  end

endmodule

// File: rtl/irq_halt_regs.sv
module irq_halt_regs
  import irq_halt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  reg_strobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] srcReq,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] enQ,
  output logic [DATA_W-1:0] flagQ,
  output logic              gateQ,
  output logic              pendingAny,
  output logic              cpuIrq
);

  logic [DATA_W-1:0] ackMask;

  assign ackMask = strobe.flagAck ? regWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      flagQ <= '0;
      gateQ <= 1'b0;
    end else begin
      if (strobe.enableWr) enQ <= regWrData;
      if (strobe.gateWr)   gateQ <= |regWrData;
      flagQ <= (flagQ & ~ackMask) | srcReq;
    end
  end

  assign pendingAny = |(enQ & flagQ);
  assign cpuIrq     = gateQ & pendingAny;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      SEL_ENABLE: regRdData = enQ;
      SEL_FLAGS:  regRdData = flagQ;
      SEL_GATE:   regRdData = {{(DATA_W-1){1'b0}}, gateQ};
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_halt_unit.sv
module irq_halt_unit
  import irq_halt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] srcReq,
  input  logic              wakeIn,
  output logic              cpuIrq,
  output logic              cpuPaused,
  output logic              stopOut
);

  reg_strobe_t       strobe;
  pwr_state_t        pwrState;
  logic [DATA_W-1:0] enQ;
  logic [DATA_W-1:0] flagQ;
  logic              gateQ;
  logic              pendingAny;

  irq_halt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .stopSel    (regWrData[STOP_BIT]),
    .pendingAny (pendingAny),
    .wakeIn     (wakeIn),
    .strobe     (strobe),
    .pwrState   (pwrState)
  );

  irq_halt_regs #(.DATA_W(DATA_W)) i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .srcReq     (srcReq),
    .regRdData  (regRdData),
    .enQ        (enQ),
    .flagQ      (flagQ),
    .gateQ      (gateQ),
    .pendingAny (pendingAny),
    .cpuIrq     (cpuIrq)
  );

  assign cpuPaused = (pwrState != PWR_RUN);
  assign stopOut   = (pwrState == PWR_STOP);

endmodule

// File: rtl/irq_halt_chk.sv
module irq_halt_chk
  import irq_halt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [DATA_W-1:0] srcReq,
  input logic              wakeIn,
  input logic              cpuIrq,
  input logic              cpuPaused,
  input logic              stopOut,
  input logic [DATA_W-1:0] enQ,
  input logic [DATA_W-1:0] flagQ,
  input logic              gateQ,
  input pwr_state_t        pwrState
);

  // R6: no interrupt while the global gate is off
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !gateQ |-> !cpuIrq);

  // R6: interrupt only with an enabled pending flag
  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> ((enQ & flagQ) != '0));

  // R5: every requested bit is set after the edge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> ((flagQ & $past(srcReq)) == $past(srcReq)));

  // R4: acknowledge without requests clears exactly the written ones
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == SEL_FLAGS && srcReq == '0)
      |=> (flagQ == ($past(flagQ) & ~$past(regWrData))));

  // R8: halt ends on the first enabled pending cycle
  p_halt_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_HALT && (enQ & flagQ) != '0) |=> !cpuPaused);

  // R9: stop persists without the wake input
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stopOut && !wakeIn) |=> stopOut);

  // R7: power-down register reads zero
  p_pwr_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SEL_POWER) |-> (regRdData == '0));

  // R3: gate reads only 0 or 1
  p_gate_bool_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == SEL_GATE) |-> (regRdData[DATA_W-1:1] == '0));

endmodule

bind irq_halt_unit irq_halt_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .srcReq    (srcReq),
  .wakeIn    (wakeIn),
  .cpuIrq    (cpuIrq),
  .cpuPaused (cpuPaused),
  .stopOut   (stopOut),
  .enQ       (enQ),
  .flagQ     (flagQ),
  .gateQ     (gateQ),
  .pwrState  (pwrState)
);

// File: tb/test_irq_halt_unit.sv
module test_irq_halt_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [15:0] srcReq = '0;
  logic        wakeIn = 1'b0;
  logic        cpuIrq;
  logic        cpuPaused;
  logic        stopOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_halt_unit i_irq_halt_unit (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .srcReq    (srcReq),
    .wakeIn    (wakeIn),
    .cpuIrq    (cpuIrq),
    .cpuPaused (cpuPaused),
    .stopOut   (stopOut)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(logic [15:0] r);
    @(negedge clk);
    srcReq = r;
    @(negedge clk);
    srcReq = '0;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); check("R1 enable", v, 16'h0);
    rd(2'd1, v); check("R1 flags", v, 16'h0);
    rd(2'd2, v); check("R1 gate", v, 16'h0);
    check("R1 outputs", {13'd0, cpuIrq, cpuPaused, stopOut}, 16'h0);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    wr(2'd0, 16'hA5C3); rd(2'd0, v); check("R2 enable A5C3", v, 16'hA5C3);
    wr(2'd0, 16'h5A3C); rd(2'd0, v); check("R2 enable 5A3C", v, 16'h5A3C);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_gate();
    logic [15:0] v;
    wr(2'd2, 16'h0040); rd(2'd2, v); check("R3 nonzero sets", v, 16'h0001);
    wr(2'd2, 16'h0000); rd(2'd2, v); check("R3 zero clears", v, 16'h0000);
    wr(2'd2, 16'h8000); rd(2'd2, v); check("R3 top bit sets", v, 16'h0001);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_flags();
    logic [15:0] v;
    pulse(16'h00F0); rd(2'd1, v); check("R5 request sets", v, 16'h00F0);
    wr(2'd1, 16'h0030); rd(2'd1, v); check("R4 ack clears ones", v, 16'h00C0);
    wr(2'd1, 16'h0000); rd(2'd1, v); check("R4 zero ack keeps", v, 16'h00C0);
    @(negedge clk);
    srcReq = 16'h0040; regAddr = 2'd1; regWrEn = 1'b1; regWrData = 16'h00C0;
    @(negedge clk);
    srcReq = '0; regWrEn = 1'b0; regWrData = '0;
    rd(2'd1, v); check("R5 set beats ack", v, 16'h0040);
  endtask

  task automatic t_irq();
    wr(2'd0, 16'h0040);
    check("R6 gate off", {15'd0, cpuIrq}, 16'h0);
    wr(2'd2, 16'h0001);
    check("R6 gated pending", {15'd0, cpuIrq}, 16'h1);
    wr(2'd0, 16'h0001);
    check("R6 unenabled flag", {15'd0, cpuIrq}, 16'h0);
    wr(2'd2, 16'h0000); wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_halt();
    logic [15:0] v;
    wr(2'd0, 16'h0002);
    wr(2'd3, 16'h0000);
    check("R8 halt entered", {14'd0, cpuPaused, stopOut}, 16'h2);
    rd(2'd3, v); check("R7 power reads zero", v, 16'h0);
    wr(2'd3, 16'h0080);
    check("R7 write ignored in halt", {14'd0, cpuPaused, stopOut}, 16'h2);
    pulse(16'h0001);
    @(negedge clk); #1;
    check("R8 unenabled stays halted", {15'd0, cpuPaused}, 16'h1);
    pulse(16'h0002);
    check("R8 one edge after set", {15'd0, cpuPaused}, 16'h1);
    @(negedge clk); #1;
    check("R8 woke without gate", {14'd0, cpuPaused, stopOut}, 16'h0);
    wr(2'd3, 16'h0000);
    check("R8 halt with pending", {15'd0, cpuPaused}, 16'h1);
    @(negedge clk); #1;
    check("R8 immediate exit", {15'd0, cpuPaused}, 16'h0);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(2'd2, 16'h0001);
    wr(2'd3, 16'h0080);
    check("R7 stop entered", {14'd0, cpuPaused, stopOut}, 16'h3);
    pulse(16'h0002);
    repeat (3) @(negedge clk);
    #1;
    check("R9 pending keeps stop", {14'd0, cpuPaused, stopOut}, 16'h3);
    check("R6 irq while stopped", {15'd0, cpuIrq}, 16'h1);
    rd(2'd3, v); check("R7 power reads zero in stop", v, 16'h0);
    @(negedge clk); wakeIn = 1'b1;
    @(negedge clk); wakeIn = 1'b0; #1;
    check("R9 wake returns to run", {14'd0, cpuPaused, stopOut}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_enable();
    t_gate();
    t_flags();
    t_irq();
    t_halt();
    t_stop();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule